// File: doc/BRIEF.md
# Ordered-Collision True Dual-Port RAM

A synchronous memory with two full read/write ports, A and B, that share one clock. Each port has an enable, a write enable, a per-byte lane mask, an address, write data and a registered read output. Reads take one clock. A write on a port does not disturb that port's own read output. This is no-change behaviour: the output keeps showing the last value that port read.

Accesses that meet at one address in the same cycle resolve by a fixed order: port A's operation happens first and port B's second. When A writes and B reads, B returns the freshly written word. When B writes and A reads, A returns the word as it was before the edge. When both write, B's bytes land over A's in every lane both enable.

Each read output has its own synchronous reset, which clears it to zero and to no other value. The reset leaves memory contents untouched and wins over a read on the same edge. Depth is two to the power of the address width. The data width must be a whole number of 8-bit lanes.

Top module: `tdp_ordered_ram`

## Requirements
- R1: A read (enable 1, write enable 0, reset 0) presents the addressed word on that port's read output after exactly one rising clock edge; the output does not change before that edge.
- R2: With a port's enable at 0, that port neither reads nor writes, whatever its write enable and mask, and its read output keeps its value.
- R3: A write (enable 1, write enable 1) leaves that port's own read output unchanged, even when the lane mask is all zero.
- R4: Mask bit i selects data bits 8*i+7 down to 8*i; a write changes only the lanes whose mask bit is 1.
- R5: When A writes and B reads the same address in one cycle, B returns the word with A's written lanes already applied.
- R6: When A reads and B writes the same address in one cycle, A returns the word held before the write, and the memory then holds B's data.
- R7: When both ports write one address in one cycle, lanes enabled by B hold B's data, lanes enabled only by A hold A's data, and other lanes keep their old value.
- R8: A port's reset, sampled high on a rising edge, sets that port's read output to zero on that edge, even when a read is requested; it alters neither the memory nor the other port's output.
- R9: Accesses by the two ports to different addresses in one cycle are independent: both writes land, and each read returns its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| pa_rst | input | 1 | Port A synchronous output reset, active high |
| pa_en | input | 1 | Port A access enable |
| pa_we | input | 1 | Port A write enable, gated by pa_en |
| pa_be | input | DATA_W/8 | Port A byte lane write mask |
| pa_addr | input | ADDR_W | Port A word address |
| pa_wdata | input | DATA_W | Port A write data |
| pa_rdata | output | DATA_W | Port A registered read data |
| pb_rst | input | 1 | Port B synchronous output reset, active high |
| pb_en | input | 1 | Port B access enable |
| pb_we | input | 1 | Port B write enable, gated by pb_en |
| pb_be | input | DATA_W/8 | Port B byte lane write mask |
| pb_addr | input | ADDR_W | Port B word address |
| pb_wdata | input | DATA_W | Port B write data |
| pb_rdata | output | DATA_W | Port B registered read data |

## Verification
The bench builds the memory with a 32-bit word and a 4-bit address, which gives four byte lanes and sixteen words. The whole array can be preloaded and compared against a bench model that applies A before B on every edge. Four lanes are enough for disjoint, overlapping and empty masks in one word, so every same-address pairing of read and write can be set up directly. Those pairings are then checked with resets applied during reads.

// File: rtl/tdpr_pkg.sv
package tdpr_pkg;

  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_READ  = 2'd1,
    PORT_WRITE = 2'd2
  } port_op_e;

  // The access enable gates the write enable.
  function automatic port_op_e decode_op(input logic en, input logic we);
    if (!en)     return PORT_IDLE;
    else if (we) return PORT_WRITE;
    else         return PORT_READ;
  endfunction

endpackage

// File: rtl/tdpr_lane_merge.sv
module tdpr_lane_merge #(
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / tdpr_pkg::LANE_W
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BYTES-1:0]  mask,
  output logic [DATA_W-1:0] merged
);

  localparam int LW = tdpr_pkg::LANE_W;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign merged[g*LW +: LW] = mask[g] ? wdata[g*LW +: LW] : base[g*LW +: LW];
  end

endmodule

// File: rtl/tdpr_rdreg.sv
module tdpr_rdreg #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  // The clear value is fixed at zero; reset beats load.
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/tdp_ordered_ram.sv
module tdp_ordered_ram #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 12,
  localparam int BYTES = DATA_W / tdpr_pkg::LANE_W
) (
  input  logic              clk,
  input  logic              pa_rst,
  input  logic              pa_en,
  input  logic              pa_we,
  input  logic [BYTES-1:0]  pa_be,
  input  logic [ADDR_W-1:0] pa_addr,
  input  logic [DATA_W-1:0] pa_wdata,
  output logic [DATA_W-1:0] pa_rdata,
  input  logic              pb_rst,
  input  logic              pb_en,
  input  logic              pb_we,
  input  logic [BYTES-1:0]  pb_be,
  input  logic [ADDR_W-1:0] pb_addr,
  input  logic [DATA_W-1:0] pb_wdata,
  output logic [DATA_W-1:0] pb_rdata
);

  import tdpr_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  port_op_e op_a, op_b;
  logic a_wr, a_rd, b_wr, b_rd, same_addr;
  logic [DATA_W-1:0] a_cur, b_cur, a_word, b_base, b_word;

  assign op_a = decode_op(pa_en, pa_we);
  assign op_b = decode_op(pb_en, pb_we);
  assign a_wr = (op_a == PORT_WRITE);
  assign a_rd = (op_a == PORT_READ);
  assign b_wr = (op_b == PORT_WRITE);
  assign b_rd = (op_b == PORT_READ);
  assign same_addr = (pa_addr == pb_addr);

  assign a_cur = mem[pa_addr];
  assign b_cur = mem[pb_addr];

  // Port A acts first, on the stored word.
  tdpr_lane_merge #(.DATA_W(DATA_W)) u_merge_a (
    .base(a_cur), .wdata(pa_wdata), .mask(pa_be), .merged(a_word)
  );

  // Port B sees the word as left by port A in the same cycle.
  assign b_base = (a_wr && same_addr) ? a_word : b_cur;

  tdpr_lane_merge #(.DATA_W(DATA_W)) u_merge_b (
    .base(b_base), .wdata(pb_wdata), .mask(pb_be), .merged(b_word)
  );

  // B's store comes last, so it wins a shared address; b_word already carries A's lanes.
  always_ff @(posedge clk) begin
    if (a_wr) mem[pa_addr] <= a_word;
    if (b_wr) mem[pb_addr] <= b_word;
  end

  tdpr_rdreg #(.DATA_W(DATA_W)) u_out_a (
    .clk(clk), .rst(pa_rst), .load(a_rd), .d(a_cur), .q(pa_rdata)
  );

  tdpr_rdreg #(.DATA_W(DATA_W)) u_out_b (
    .clk(clk), .rst(pb_rst), .load(b_rd), .d(b_base), .q(pb_rdata)
  );

  assert_clear_a_R8: assert property (@(posedge clk) pa_rst |=> (pa_rdata == '0));
  assert_clear_b_R8: assert property (@(posedge clk) pb_rst |=> (pb_rdata == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (pa_rst)
    !pa_en |=> $stable(pa_rdata));

  assert_a_nochange_R3: assert property (@(posedge clk) disable iff (pa_rst)
    (pa_en && pa_we) |=> $stable(pa_rdata));

  assert_b_nochange_R3: assert property (@(posedge clk) disable iff (pb_rst)
    (pb_en && pb_we) |=> $stable(pb_rdata));

  assert_fwd_R5: assert property (@(posedge clk) disable iff (pb_rst)
    (a_wr && b_rd && same_addr && (&pa_be)) |=> (pb_rdata == $past(pa_wdata)));

  assert_b_last_R7: assert property (@(posedge clk) disable iff (pb_rst)
    (a_wr && b_wr && same_addr && (&pb_be)) |=> (mem[$past(pb_addr)] == $past(pb_wdata)));

endmodule

// File: tb/test_tdp_ordered_ram.sv
module test_tdp_ordered_ram;

  localparam int DW = 32;
  localparam int AW = 4;
  localparam int NB = DW / 8;
  localparam int NW = 1 << AW;

  typedef struct packed {
    logic          ar, ae, aw;
    logic [NB-1:0] abe;
    logic [AW-1:0] aa;
    logic [DW-1:0] ad;
    logic          br, ben, bw;
    logic [NB-1:0] bbe;
    logic [AW-1:0] ba;
    logic [DW-1:0] bd;
    logic [3:0]    tag;
  } vec_t;

  function automatic vec_t mk(
    input logic ar, ae, aw, input logic [NB-1:0] abe, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
    input logic br, ben, bw, input logic [NB-1:0] bbe, input logic [AW-1:0] ba, input logic [DW-1:0] bd,
    input logic [3:0] tag);
    return '{ar, ae, aw, abe, aa, ad, br, ben, bw, bbe, ba, bd, tag};
  endfunction

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    mk(0,1,0,4'h0, 3,32'h0,          0,1,0,4'h0, 5,32'h0,          1), // R1 plain reads
    mk(0,1,1,4'hF, 3,32'hD1D1_0001,  0,1,0,4'h0, 3,32'h0,          5), // R5 A write, B read
    mk(0,1,0,4'h0, 7,32'h0,          0,1,1,4'hF, 7,32'hD2D2_0002,  6), // R6 A read old, B write
    mk(0,1,0,4'h0, 7,32'h0,          0,0,0,4'h0, 7,32'h0,          6), // R6 B data stored; R2 B idle
    mk(0,1,1,4'h5, 9,32'hA3A3_A3A3,  0,1,1,4'h3, 9,32'hB4B4_B4B4,  7), // R7 overlapping lanes
    mk(0,1,0,4'h0, 9,32'h0,          0,1,0,4'h0, 9,32'h0,          7), // R7 read back
    mk(0,1,1,4'h8, 2,32'hEE00_0000,  0,1,0,4'h0, 2,32'h0,          4), // R4 one lane, forwarded
    mk(0,0,1,4'hF, 4,32'hBAD0_0000,  0,0,1,4'hF, 4,32'hBAD1_1111,  2), // R2 writes without enable
    mk(0,1,0,4'h0, 4,32'h0,          0,1,0,4'h0, 4,32'h0,          2), // R2 nothing landed
    mk(0,1,1,4'h0, 6,32'hFFFF_FFFF,  0,1,1,4'hF, 8,32'h8888_0008,  3), // R3 empty mask; R9
    mk(0,1,0,4'h0, 8,32'h0,          0,1,0,4'h0, 6,32'h0,          9), // R9 independent
    mk(1,1,0,4'h0,10,32'h0,          0,1,0,4'h0,10,32'h0,          8), // R8 A reset over read
    mk(0,1,0,4'h0,10,32'h0,          1,1,0,4'h0,11,32'h0,          8), // R8 B reset over read
    mk(0,1,0,4'h0,11,32'h0,          0,1,0,4'h0,10,32'h0,          8), // R8 memory untouched
    mk(0,1,1,4'h9, 1,32'h1111_1111,  0,1,1,4'h6, 1,32'h2222_2222,  7), // R7 disjoint lanes
    mk(0,1,0,4'h0, 1,32'h0,          0,1,0,4'h0, 1,32'h0,          7)  // R7 read back
  };

  logic clk = 0;
  logic pa_rst, pa_en, pa_we, pb_rst, pb_en, pb_we;
  logic [NB-1:0] pa_be, pb_be;
  logic [AW-1:0] pa_addr, pb_addr;
  logic [DW-1:0] pa_wdata, pb_wdata, pa_rdata, pb_rdata;

  always #4 clk = ~clk;

  tdp_ordered_ram #(.DATA_W(DW), .ADDR_W(AW)) i_tdp_ordered_ram (
    .clk(clk),
    .pa_rst(pa_rst), .pa_en(pa_en), .pa_we(pa_we), .pa_be(pa_be),
    .pa_addr(pa_addr), .pa_wdata(pa_wdata), .pa_rdata(pa_rdata),
    .pb_rst(pb_rst), .pb_en(pb_en), .pb_we(pb_we), .pb_be(pb_be),
    .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_rdata(pb_rdata)
  );

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] ref_mem [NW];
  logic [DW-1:0] exp_a, exp_b;

  function automatic logic [DW-1:0] lanes(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [NB-1:0] m);
    logic [DW-1:0] r = old;
    for (int i = 0; i < NB; i++) if (m[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge and advance the model: A first, then B.
  task automatic apply(input vec_t v);
    pa_rst = v.ar; pa_en = v.ae; pa_we = v.aw; pa_be = v.abe; pa_addr = v.aa; pa_wdata = v.ad;
    pb_rst = v.br; pb_en = v.ben; pb_we = v.bw; pb_be = v.bbe; pb_addr = v.ba; pb_wdata = v.bd;
    if (v.ar) exp_a = '0;
    else if (v.ae && !v.aw) exp_a = ref_mem[v.aa];
    if (v.ae && v.aw) ref_mem[v.aa] = lanes(ref_mem[v.aa], v.ad, v.abe);
    if (v.br) exp_b = '0;
    else if (v.ben && !v.bw) exp_b = ref_mem[v.ba];
    if (v.ben && v.bw) ref_mem[v.ba] = lanes(ref_mem[v.ba], v.bd, v.bbe);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    string tg;
    exp_a = '0; exp_b = '0;
    for (int i = 0; i < NW; i++) ref_mem[i] = '0;
    @(negedge clk);
    apply(mk(1,0,0,4'h0,0,32'h0, 1,0,0,4'h0,0,32'h0, 8));
    check("R8 reset state A", pa_rdata, '0);
    check("R8 reset state B", pb_rdata, '0);

    // Preload every word, A and B on different addresses each cycle.
    for (int i = 0; i < NW / 2; i++) begin
      apply(mk(0,1,1,4'hF, AW'(i), 32'hA000_0000 | i,
               0,1,1,4'hF, AW'(i + NW/2), 32'hB000_0000 | (i + NW/2), 9));
      check("R3 A output held on write", pa_rdata, exp_a);
      check("R3 B output held on write", pb_rdata, exp_b);
    end

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k]);
      tg = $sformatf("R%0d vector %0d", VEC[k].tag, k);
      check({tg, " port A"}, pa_rdata, exp_a);
      check({tg, " port B"}, pb_rdata, exp_b);
    end

    // R1: the output holds until the edge, then shows the word.
    pa_rst = 0; pa_en = 1; pa_we = 0; pa_addr = 4'd12;
    pb_rst = 0; pb_en = 0; pb_we = 0;
    #1 check("R1 no change before edge", pa_rdata, exp_a);
    @(posedge clk); @(negedge clk);
    check("R1 one cycle latency", pa_rdata, 32'hB000_000C);
    exp_a = 32'hB000_000C;

    // R8: reset on A during a B read of the same word leaves B's read intact.
    apply(mk(1,1,0,4'h0,5,32'h0, 0,1,0,4'h0,5,32'h0, 8));
    check("R8 A cleared", pa_rdata, '0);
    check("R8 B unaffected", pb_rdata, 32'hA000_0005);

    // R6: full-word write by B with A reading the same address.
    apply(mk(0,1,0,4'h0,0,32'h0, 0,1,1,4'hF,0,32'h600D_0000, 6));
    check("R6 A old word", pa_rdata, 32'hA000_0000);
    apply(mk(0,0,0,4'h0,0,32'h0, 0,1,0,4'h0,0,32'h0, 6));
    check("R6 new word stored", pb_rdata, 32'h600D_0000);
    check("R2 A idle holds", pa_rdata, 32'hA000_0000);

    summary();
  end

endmodule